// File: doc/BRIEF.md
# Secure session access state controller

This block holds the security state of one protected memory session. It watches result pulses from three neighbours: the password comparator, the authentication engine and the checksum checker. From these it keeps three things: which password set is active and whether it carries write rights, which key last authenticated, and whether the session is in standard, authenticated or encrypted mode. It also counts consecutive failed attempts and locks out further attempts after the fourth failure.

For each user zone the block computes a read grant and a write grant. Each grant is built from the zone's configuration word and the session state. The transport layer and the crypto engines use these grants and the current mode to accept or refuse commands. All state changes occur on the rising clock edge. The grants and the mode are combinational functions of that state and of the zone configuration, so they reflect an event from the first edge after it. Every input here is a plain control pulse, so there is no valid/ready stream and no back-pressure.

Top module: `sess_access_ctrl`

## Requirements
- R1: After `rst_n` is low, the mode is standard (`mode` = 0), the lockout is clear, no password is active and no key is authenticated.
- R2: A passing password attempt (`att_kind` = 0) makes set `att_idx` the only active password. With `att_wr` = 1 it grants write and read on zones guarded by that set. With `att_wr` = 0 it grants read only. A later passing attempt replaces the earlier one.
- R3: A failing password attempt removes any active password.
- R4: A passing authentication attempt (`att_kind` = 1) sets mode to authenticated (`mode` = 1) with key `att_idx[1:0]`, even from encrypted mode. A failing authentication attempt returns the mode to standard.
- R5: An `enc_req` pulse moves the mode to encrypted (`mode` = 2) only when the mode is authenticated and `enc_key` equals the authenticated key. In every other case it has no effect.
- R6: `mac_bad` in authenticated or encrypted mode returns the mode to standard and discards any attempt or activation in the same cycle. In standard mode, `mac_bad` has no effect.
- R7: Each failing attempt raises a failure count, and each passing attempt clears it. The count saturates at 4. While it is 4, `locked` is high and attempts change nothing. Only `rst_n` clears the lockout.
- R8: `sess_rst` clears the active password, the authentication and the mode, but keeps the failure count. It overrides every other input in its cycle.
- R9: Zone z uses `zone_cfg[8z+7:8z]`. Bit 0 enables password guarding, bits 3:1 select the password set, bit 4 requires authentication, bits 6:5 select the key, and bit 7 requires encryption. Read is granted only when every enabled guard is met. Authentication needs a non-standard mode with the selected key. Encryption needs encrypted mode with the selected key. Write additionally needs write rights when password guarding is enabled.
- R10: When `att_valid` and `enc_req` arrive in the same cycle, the attempt is processed and the activation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sess_rst | input | 1 | Session reset pin, active high, synchronous |
| att_valid | input | 1 | One attempt result this cycle |
| att_kind | input | 1 | 0 = password attempt, 1 = authentication attempt |
| att_pass | input | 1 | Attempt succeeded |
| att_idx | input | 3 | Password set, or key in bits 1:0 |
| att_wr | input | 1 | Password carries write rights |
| enc_req | input | 1 | Encryption activation request |
| enc_key | input | 2 | Key named by the activation |
| mac_bad | input | 1 | Checksum mismatch on the current command |
| zone_cfg | input | 128 | Eight configuration bits per zone |
| rd_grant | output | 16 | Per-zone read grant |
| wr_grant | output | 16 | Per-zone write grant |
| mode | output | 2 | 0 standard, 1 authenticated, 2 encrypted |
| locked | output | 1 | Failure count has reached the limit |

## Verification
A corrupted mode register appears on `mode` and on the grants of key-guarded zones one edge after the event that should have set it. A lost or stale password shows on the grants of password-guarded zones at that same edge. A miscounting failure counter may stay hidden until the fourth failure, when `locked` rises too early or too late, or until an attempt after lockout changes a grant. The bench compares every output after every cycle against a model and drives long random runs, so a divergence surfaces within one cycle of the stimulus that exposes it.

// File: rtl/sess_pkg.sv
package sess_pkg;
  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_AUTH = 2'd1,
    MODE_ENC  = 2'd2
  } sess_mode_e;

  localparam logic KIND_PW   = 1'b0;
  localparam logic KIND_AUTH = 1'b1;
endpackage

// File: rtl/sess_fail_counter.sv
module sess_fail_counter #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic pass,
  output logic locked
);
  logic [CNT_W-1:0] cnt_q;

  assign locked = (cnt_q == CNT_W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take) begin
      if (pass) begin
        cnt_q <= '0;
      end else if (!locked) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sess_state.sv
module sess_state
  import sess_pkg::*;
#(
  parameter int unsigned PW_W  = 3,
  parameter int unsigned KEY_W = 2,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sess_rst,
  input  logic             mac_abort,
  input  logic             att_take,
  input  logic             att_kind,
  input  logic             att_pass,
  input  logic [IDX_W-1:0] att_idx,
  input  logic             att_wr,
  input  logic             enc_take,
  input  logic [KEY_W-1:0] enc_key,
  output logic             pw_act,
  output logic [PW_W-1:0]  pw_idx,
  output logic             pw_wr,
  output sess_mode_e       mode_q,
  output logic [KEY_W-1:0] key_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_act <= 1'b0;
      pw_idx <= '0;
      pw_wr  <= 1'b0;
      mode_q <= MODE_STD;
      key_q  <= '0;
    end else if (sess_rst) begin
      pw_act <= 1'b0;
      pw_wr  <= 1'b0;
      mode_q <= MODE_STD;
    end else if (mac_abort) begin
      mode_q <= MODE_STD;
    end else if (att_take) begin
      if (att_kind == KIND_PW) begin
        if (att_pass) begin
          pw_act <= 1'b1;
          pw_idx <= att_idx[PW_W-1:0];
          pw_wr  <= att_wr;
        end else begin
          pw_act <= 1'b0;
          pw_wr  <= 1'b0;
        end
      end else if (att_pass) begin
        mode_q <= MODE_AUTH;
        key_q  <= att_idx[KEY_W-1:0];
      end else begin
        mode_q <= MODE_STD;
      end
    end else if (enc_take && mode_q == MODE_AUTH && enc_key == key_q) begin
      mode_q <= MODE_ENC;
    end
  end
endmodule

// File: rtl/sess_zone_gate.sv
module sess_zone_gate
  import sess_pkg::*;
#(
  parameter int unsigned PW_W  = 3,
  parameter int unsigned KEY_W = 2,
  parameter int unsigned CFG_W = 8
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             pw_act,
  input  logic [PW_W-1:0]  pw_idx,
  input  logic             pw_wr,
  input  sess_mode_e       mode_q,
  input  logic [KEY_W-1:0] key_q,
  output logic             rd,
  output logic             wr
);
  localparam int unsigned AUTH_BIT = PW_W + 1;
  localparam int unsigned KEY_LO   = PW_W + 2;
  localparam int unsigned ENC_BIT  = CFG_W - 1;

  logic            pw_guard, auth_guard, enc_guard;
  logic [PW_W-1:0] pw_set;
  logic [KEY_W-1:0] key_sel;
  logic            pw_rd_ok, pw_wr_ok, auth_ok, enc_ok, key_match;

  always_comb begin
    pw_guard   = cfg[0];
    pw_set     = cfg[PW_W:1];
    auth_guard = cfg[AUTH_BIT];
    key_sel    = cfg[KEY_LO +: KEY_W];
    enc_guard  = cfg[ENC_BIT];
    key_match  = (key_q == key_sel);
    pw_rd_ok   = !pw_guard || (pw_act && pw_idx == pw_set);
    pw_wr_ok   = !pw_guard || (pw_act && pw_idx == pw_set && pw_wr);
    auth_ok    = !auth_guard || (mode_q != MODE_STD && key_match);
    enc_ok     = !enc_guard || (mode_q == MODE_ENC && key_match);
    rd         = pw_rd_ok && auth_ok && enc_ok;
    wr         = pw_wr_ok && auth_ok && enc_ok;
  end
endmodule

// File: rtl/sess_access_ctrl.sv
module sess_access_ctrl
  import sess_pkg::*;
#(
  parameter int unsigned N_ZONES    = 16,
  parameter int unsigned N_PW       = 8,
  parameter int unsigned N_KEYS     = 4,
  parameter int unsigned FAIL_LIMIT = 4,
  localparam int unsigned PW_W  = $clog2(N_PW),
  localparam int unsigned KEY_W = $clog2(N_KEYS),
  localparam int unsigned IDX_W = (PW_W > KEY_W) ? PW_W : KEY_W,
  localparam int unsigned CFG_W = PW_W + KEY_W + 3,
  localparam int unsigned CNT_W = $clog2(FAIL_LIMIT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sess_rst,
  input  logic                     att_valid,
  input  logic                     att_kind,
  input  logic                     att_pass,
  input  logic [IDX_W-1:0]         att_idx,
  input  logic                     att_wr,
  input  logic                     enc_req,
  input  logic [KEY_W-1:0]         enc_key,
  input  logic                     mac_bad,
  input  logic [N_ZONES*CFG_W-1:0] zone_cfg,
  output logic [N_ZONES-1:0]       rd_grant,
  output logic [N_ZONES-1:0]       wr_grant,
  output logic [1:0]               mode,
  output logic                     locked
);
  sess_mode_e       mode_q;
  logic [KEY_W-1:0] key_q;
  logic             pw_act, pw_wr;
  logic [PW_W-1:0]  pw_idx;
  logic             mac_abort, att_take, enc_take;

  assign mac_abort = mac_bad && (mode_q != MODE_STD);
  assign att_take  = att_valid && !locked && !sess_rst && !mac_abort;
  assign enc_take  = enc_req && !att_valid && !sess_rst && !mac_abort;
  assign mode      = mode_q;

  sess_fail_counter #(.LIMIT(FAIL_LIMIT), .CNT_W(CNT_W)) fail_i (
    .clk(clk), .rst_n(rst_n), .take(att_take), .pass(att_pass), .locked(locked)
  );

  sess_state #(.PW_W(PW_W), .KEY_W(KEY_W), .IDX_W(IDX_W)) state_i (
    .clk(clk), .rst_n(rst_n), .sess_rst(sess_rst), .mac_abort(mac_abort),
    .att_take(att_take), .att_kind(att_kind), .att_pass(att_pass),
    .att_idx(att_idx), .att_wr(att_wr), .enc_take(enc_take), .enc_key(enc_key),
    .pw_act(pw_act), .pw_idx(pw_idx), .pw_wr(pw_wr), .mode_q(mode_q), .key_q(key_q)
  );

  for (genvar z = 0; z < N_ZONES; z++) begin : g_zone
    sess_zone_gate #(.PW_W(PW_W), .KEY_W(KEY_W), .CFG_W(CFG_W)) gate_i (
      .cfg(zone_cfg[z*CFG_W +: CFG_W]), .pw_act(pw_act), .pw_idx(pw_idx),
      .pw_wr(pw_wr), .mode_q(mode_q), .key_q(key_q),
      .rd(rd_grant[z]), .wr(wr_grant[z])
    );
  end
endmodule

// File: rtl/sess_access_chk.sv
module sess_access_chk #(
  parameter int unsigned N_ZONES = 16,
  parameter int unsigned CFG_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sess_rst,
  input logic                     att_valid,
  input logic                     mac_bad,
  input logic [N_ZONES*CFG_W-1:0] zone_cfg,
  input logic [N_ZONES-1:0]       rd_grant,
  input logic [N_ZONES-1:0]       wr_grant,
  input logic [1:0]               mode,
  input logic                     locked
);
  logic [N_ZONES-1:0] enc_mask;
  always_comb begin
    for (int z = 0; z < N_ZONES; z++) enc_mask[z] = zone_cfg[z*CFG_W + CFG_W - 1];
  end

  // R5
  no_enc_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |=> (mode != 2'd2));
  // R8
  sess_rst_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sess_rst |=> (mode == 2'd0));
  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R7
  lock_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && att_valid && !sess_rst && !mac_bad) |=> $stable(mode));
  // R6
  mac_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_bad && mode != 2'd0 && !sess_rst) |=> (mode == 2'd0));
  // R9
  enc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rd_grant & enc_mask)) |-> (mode == 2'd2));
  // R2
  wr_has_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_grant & ~rd_grant) == '0);
  // R4
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);
endmodule

bind sess_access_ctrl sess_access_chk #(.N_ZONES(N_ZONES), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sess_rst(sess_rst), .att_valid(att_valid),
  .mac_bad(mac_bad), .zone_cfg(zone_cfg), .rd_grant(rd_grant),
  .wr_grant(wr_grant), .mode(mode), .locked(locked)
);

// File: tb/sess_access_ctrl_tb.sv
module sess_access_ctrl_tb_top;
  localparam int NZ = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sess_rst = 1'b0, att_valid = 1'b0, att_kind = 1'b0, att_pass = 1'b0;
  logic [2:0]    att_idx = '0;
  logic          att_wr = 1'b0, enc_req = 1'b0, mac_bad = 1'b0;
  logic [1:0]    enc_key = '0;
  logic [NZ*8-1:0] zone_cfg = '0;
  logic [NZ-1:0] rd_grant, wr_grant;
  logic [1:0]    mode;
  logic          locked;

  int ncmp = 0, nerr = 0;
  bit done = 0;

  // reference state
  bit       m_pw_act, m_pw_wr;
  bit [2:0] m_pw_idx;
  int       m_mode, m_cnt;
  bit [1:0] m_key;

  always #10 clk = ~clk;

  sess_access_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sess_rst(sess_rst), .att_valid(att_valid),
    .att_kind(att_kind), .att_pass(att_pass), .att_idx(att_idx), .att_wr(att_wr),
    .enc_req(enc_req), .enc_key(enc_key), .mac_bad(mac_bad), .zone_cfg(zone_cfg),
    .rd_grant(rd_grant), .wr_grant(wr_grant), .mode(mode), .locked(locked)
  );

  function automatic bit exp_grant(int z, bit want_wr);
    logic [7:0] c = zone_cfg[z*8 +: 8];
    bit pr, pw, au, en;
    pr = !c[0] || (m_pw_act && m_pw_idx == c[3:1]);
    pw = !c[0] || (m_pw_act && m_pw_idx == c[3:1] && m_pw_wr);
    au = !c[4] || (m_mode != 0 && m_key == c[6:5]);
    en = !c[7] || (m_mode == 2 && m_key == c[6:5]);
    return (want_wr ? pw : pr) && au && en;
  endfunction

  function automatic void model_clear();
    m_pw_act = 0; m_pw_wr = 0; m_pw_idx = 0; m_mode = 0; m_key = 0; m_cnt = 0;
  endfunction

  function automatic void model_step();
    if (sess_rst) begin
      m_pw_act = 0; m_pw_wr = 0; m_mode = 0;
    end else if (mac_bad && m_mode != 0) begin
      m_mode = 0;
    end else if (att_valid) begin
      if (m_cnt < 4) begin
        if (att_pass) m_cnt = 0; else m_cnt = m_cnt + 1;
        if (!att_kind) begin
          if (att_pass) begin m_pw_act = 1; m_pw_idx = att_idx; m_pw_wr = att_wr; end
          else begin m_pw_act = 0; m_pw_wr = 0; end
        end else begin
          if (att_pass) begin m_mode = 1; m_key = att_idx[1:0]; end
          else m_mode = 0;
        end
      end
    end else if (enc_req && m_mode == 1 && enc_key == m_key) begin
      m_mode = 2;
    end
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [NZ-1:0] er, ew;
    for (int z = 0; z < NZ; z++) begin
      er[z] = exp_grant(z, 1'b0);
      ew[z] = exp_grant(z, 1'b1);
    end
    cmp(tag, "mode", int'(mode), m_mode);
    cmp(tag, "locked", int'(locked), int'(m_cnt == 4));
    cmp(tag, "rd_grant", int'(rd_grant), int'(er));
    cmp(tag, "wr_grant", int'(wr_grant), int'(ew));
  endtask

  // called at a falling edge; drives one cycle of inputs and checks the result
  task automatic step(string tag, bit sr, bit av, bit ak, bit ap, bit [2:0] ai,
                      bit aw, bit er, bit [1:0] ek, bit mb);
    sess_rst = sr; att_valid = av; att_kind = ak; att_pass = ap; att_idx = ai;
    att_wr = aw; enc_req = er; enc_key = ek; mac_bad = mb;
    @(posedge clk);
    model_step();
    #4;
    compare_all(tag);
    @(negedge clk);
    sess_rst = 0; att_valid = 0; enc_req = 0; mac_bad = 0;
  endtask

  task automatic pw(string tag, bit ap, bit [2:0] s, bit w);
    step(tag, 0, 1, 0, ap, s, w, 0, 0, 0);
  endtask
  task automatic au(string tag, bit ap, bit [1:0] k);
    step(tag, 0, 1, 1, ap, {1'b0, k}, 0, 0, 0, 0);
  endtask
  task automatic enc(string tag, bit [1:0] k);
    step(tag, 0, 0, 0, 0, 0, 0, 1, k, 0);
  endtask

  task automatic power_reset(string tag);
    rst_n = 0;
    @(posedge clk);
    model_clear();
    #4;
    compare_all(tag);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    // zone0 open, zone1 pw set 2, zone2 auth key1, zone3 enc key1, zone4 pw5 + enc key2
    zone_cfg = '0;
    zone_cfg[1*8 +: 8] = 8'h05;
    zone_cfg[2*8 +: 8] = 8'h30;
    zone_cfg[3*8 +: 8] = 8'hA0;
    zone_cfg[4*8 +: 8] = 8'hCB;
    @(negedge clk);
    power_reset("R1");
    cmp("R1", "mode literal", int'(mode), 0);
    cmp("R1", "locked literal", int'(locked), 0);
    cmp("R1", "zone1 read literal", int'(rd_grant[1]), 0);
    cmp("R1", "zone0 read literal", int'(rd_grant[0]), 1);

    pw("R2", 1, 3'd2, 0);
    cmp("R2", "zone1 rd/wr literal", int'({rd_grant[1], wr_grant[1]}), 2);
    pw("R2", 1, 3'd2, 1);
    cmp("R2", "zone1 rd/wr literal", int'({rd_grant[1], wr_grant[1]}), 3);
    pw("R2", 1, 3'd5, 1);
    pw("R3", 0, 3'd5, 1);
    cmp("R3", "zone4 rd literal", int'(rd_grant[4]), 0);

    au("R4", 1, 2'd1);
    cmp("R4", "mode literal", int'(mode), 1);
    enc("R5", 2'd2);
    cmp("R5", "mode after wrong key", int'(mode), 1);
    enc("R5", 2'd1);
    cmp("R5", "mode literal", int'(mode), 2);
    cmp("R9", "zone3 rd literal", int'(rd_grant[3]), 1);
    au("R4", 1, 2'd2);
    cmp("R4", "enc to auth literal", int'(mode), 1);
    step("R6", 0, 1, 0, 1, 3'd2, 1, 0, 0, 1);
    cmp("R6", "mode after mac", int'(mode), 0);
    cmp("R6", "abandoned pw", int'(rd_grant[1]), 0);
    step("R6", 0, 1, 0, 1, 3'd2, 1, 0, 0, 1);
    cmp("R6", "pw taken in std", int'(rd_grant[1]), 1);
    au("R10", 1, 2'd2);
    step("R10", 0, 1, 1, 1, 3'd2, 0, 1, 2'd2, 0);
    cmp("R10", "enc dropped", int'(mode), 1);
    pw("R9", 1, 3'd5, 1);
    enc("R9", 2'd2);
    cmp("R9", "zone4 wr literal", int'(wr_grant[4]), 1);
    au("R4", 0, 2'd2);
    cmp("R4", "fail to std", int'(mode), 0);

    au("R7", 0, 2'd0);
    pw("R7", 0, 3'd1, 0);
    cmp("R7", "not yet locked", int'(locked), 0);
    au("R7", 0, 2'd3);
    cmp("R7", "locked literal", int'(locked), 1);
    au("R7", 1, 2'd1);
    cmp("R7", "ignored when locked", int'(mode), 0);
    pw("R7", 1, 3'd2, 1);
    cmp("R7", "pw ignored when locked", int'(rd_grant[1]), 0);
    step("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    cmp("R8", "lock kept", int'(locked), 1);
    power_reset("R1");
    pw("R8", 1, 3'd2, 1);
    au("R8", 1, 2'd1);
    step("R8", 1, 1, 1, 1, 3'd3, 0, 0, 0, 0);
    cmp("R8", "mode cleared", int'(mode), 0);
    cmp("R8", "pw cleared", int'(rd_grant[1]), 0);

    for (int i = 0; i < 4000; i++) begin
      bit [3:0] r;
      if (i % 64 == 0) begin
        for (int z = 0; z < NZ; z++) zone_cfg[z*8 +: 8] = 8'($urandom);
      end
      if ($urandom_range(0, 199) == 0) begin
        power_reset("R1");
      end else begin
        r = 4'($urandom);
        step(r[0] ? "R9" : "R7",
             $urandom_range(0, 29) == 0,
             $urandom_range(0, 2) != 0,
             1'($urandom),
             $urandom_range(0, 9) < 6,
             3'($urandom),
             1'($urandom),
             $urandom_range(0, 2) == 0,
             2'($urandom),
             $urandom_range(0, 14) == 0);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule